// File: doc/BRIEF.md
# Four-Phase Handshake Bus Slave

This block is the target end of a simple asynchronous parallel bus with a 16-bit address, separate 8-bit data paths in each direction, an active-low select, a read-not-write line and an active-low completion signal. The master sets up address, direction and write data, then pulls select low. The slave answers by pulling its completion line low once the transfer is done. The master then releases select, and the slave releases completion. Only then may the next transfer start.

Every bus input comes from another timing domain. It passes through a two-stage synchroniser before the control logic uses it. A small window of byte registers, held in an internal memory, sits at a parameterised base address. Reads outside the window return 0xFF but still complete. A response delay parameter adds a fixed number of clocks before completion. An active-low bus reset from the host side aborts any transfer in progress.

Top module: `hsb_slave`

## Requirements
- R1: After the synchronous reset `rst`, `done_n` is 1 and `rdata` is 0x00.
- R2: While no transfer is under way, `done_n` stays 1.
- R3: `done_n` falls on the (RESP_DLY+3)-th rising clock edge after `sel_n` falls. Two of those edges are synchroniser stages, so RESP_DLY=0 completes on the edge after the synchronised select is seen low.
- R4: For a read (`rd_wr`=1) inside the window, `rdata` holds the stored byte no later than the edge on which `done_n` falls. The window is the 16 bytes whose address bits [15:4] match BASE[15:4], and bits [3:0] select the byte.
- R5: A write (`rd_wr`=0) inside the window stores `wdata` at the addressed byte on the edge where `done_n` falls. A later read returns that byte.
- R6: A read outside the window returns 0xFF in `rdata` and still completes the handshake.
- R7: A write outside the window completes the handshake and changes no stored byte, including the in-window byte with the same low four address bits.
- R8: `done_n` stays 0 while `sel_n` is held low. It returns to 1 on the third rising edge after `sel_n` rises.
- R9: Holding `sel_n` low after completion never starts a second transfer. A new transfer needs `sel_n` to go high and then low again.
- R10: While `bus_rst_n` is 0, `done_n` is 1 from the third rising edge after `bus_rst_n` falls onward.
- R11: A transfer cut off by bus reset does not complete, and its write does not land. After `bus_rst_n` returns to 1, `done_n` stays 1 until `sel_n` has been seen high and a fresh transfer begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset of the slave logic |
| bus_rst_n | input | 1 | Active-low bus reset from the host side (asynchronous) |
| sel_n | input | 1 | Active-low transfer select (asynchronous) |
| rd_wr | input | 1 | 1 = read, 0 = write (asynchronous) |
| addr | input | 16 | Byte address, stable while `sel_n` is low |
| wdata | input | 8 | Write data, stable while `sel_n` is low |
| rdata | output | 8 | Read data, valid when `done_n` falls after a read |
| done_n | output | 1 | Active-low transfer completion |

## Verification
The hardest situation to reach from the ports is a bus reset that lands inside the response-delay window. Select has already been synchronised low there, but completion has not fired yet. The stimulus drops `sel_n` and pulls `bus_rst_n` low one clock later. With the default delay this makes the synchronised reset arrive before the completion edge. The bench then keeps select low across the release to show that the dead transfer neither completes nor writes. A second directed case resets the bus while completion is already low. Random in-window and out-of-window transfers with random hold times cover the rest.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DONE  = 2'd2,
    ST_REARM = 2'd3
  } hsb_state_e;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsb_regfile.sv
module hsb_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdat,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdat
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
  end

  assign rdat = mem[ridx];
endmodule

// File: rtl/hsb_fsm.sv
module hsb_fsm
  import hsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W = 4,
  parameter logic [ADDR_W-1:0] BASE = 16'h0040,
  parameter int RESP_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_s,
  input  logic              brst_s,
  input  logic              rnw_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] wdata_s,
  input  logic [DATA_W-1:0] mem_rd,
  output logic              we,
  output logic [IDX_W-1:0]  idx,
  output logic              done_n,
  output logic [DATA_W-1:0] rdata
);
  localparam int CW = (RESP_DLY > 0) ? $clog2(RESP_DLY + 1) : 1;
  localparam logic [DATA_W-1:0] MISS_VAL = '1;

  hsb_state_e state;
  logic [CW-1:0] cnt;
  logic done_q;
  logic hit;
  logic fire;

  assign idx = addr_s[IDX_W-1:0];
  assign hit = (addr_s[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W]);

  always_comb begin
    fire = 1'b0;
    if (brst_s && !sel_s) begin
      if (state == ST_IDLE && RESP_DLY == 0) fire = 1'b1;
      if (state == ST_WAIT && cnt == CW'(1)) fire = 1'b1;
    end
  end

  assign we = fire && !rnw_s && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      done_q <= 1'b1;
      rdata  <= '0;
    end else if (!brst_s) begin
      state  <= ST_REARM;
      done_q <= 1'b1;
    end else begin
      if (fire) begin
        state  <= ST_DONE;
        done_q <= 1'b0;
        if (rnw_s) rdata <= hit ? mem_rd : MISS_VAL;
      end else begin
        unique case (state)
          ST_IDLE: if (!sel_s) begin
            cnt   <= CW'(RESP_DLY);
            state <= ST_WAIT;
          end
          ST_WAIT: begin
            if (sel_s) state <= ST_IDLE;
            else       cnt <= cnt - CW'(1);
          end
          ST_DONE: if (sel_s) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
          ST_REARM: if (sel_s) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_n = done_q;

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> done_q);
  assert_fall_needs_sel_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(done_q) |-> !$past(sel_s));
  assert_hold_low_R8: assert property (@(posedge clk) disable iff (rst)
    (!done_q && !sel_s && brst_s) |=> !done_q);
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (!done_q && sel_s) |=> done_q);
  assert_busrst_R10: assert property (@(posedge clk) disable iff (rst)
    !brst_s |=> done_q);
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
    we |=> (idx != $past(idx) || mem_rd == $past(wdata_s)));
  assert_miss_ff_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && rnw_s && !hit) |=> (rdata == MISS_VAL));
endmodule

// File: rtl/hsb_slave.sv
module hsb_slave #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W = 4,
  parameter logic [ADDR_W-1:0] BASE = 16'h0040,
  parameter int RESP_DLY = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst_n,
  input  logic              sel_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done_n
);
  localparam int DW = 1 + ADDR_W + DATA_W;

  logic [1:0]        ctl_s;
  logic [DW-1:0]     dat_s;
  logic              we;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mem_rd;

  hsb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({bus_rst_n, sel_n}), .q(ctl_s)
  );

  hsb_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst(rst), .d({rd_wr, addr, wdata}), .q(dat_s)
  );

  hsb_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .BASE(BASE), .RESP_DLY(RESP_DLY)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .sel_s(ctl_s[0]), .brst_s(ctl_s[1]),
    .rnw_s(dat_s[DW-1]),
    .addr_s(dat_s[DW-2:DATA_W]),
    .wdata_s(dat_s[DATA_W-1:0]),
    .mem_rd(mem_rd), .we(we), .idx(idx),
    .done_n(done_n), .rdata(rdata)
  );

  hsb_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .we(we), .widx(idx), .wdat(dat_s[DATA_W-1:0]),
    .ridx(idx), .rdat(mem_rd)
  );
endmodule

// File: tb/sim_hsb_slave.sv
module sim_hsb_slave;
  localparam int DLY = 2;
  localparam logic [15:0] BASE = 16'h0040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_rst_n = 1'b1;
  logic sel_n = 1'b1;
  logic rd_wr = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic done_n;

  int tests = 0;
  int fails = 0;
  bit ended = 0;
  logic [7:0] model [16];

  always #2 clk = ~clk;

  hsb_slave #(.BASE(BASE), .RESP_DLY(DLY)) u0 (
    .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .sel_n(sel_n),
    .rd_wr(rd_wr), .addr(addr), .wdata(wdata), .rdata(rdata), .done_n(done_n)
  );

  function automatic bit in_win(input logic [15:0] a);
    return a[15:4] == BASE[15:4];
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    return in_win(a) ? model[a[3:0]] : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [15:0] a, input logic [7:0] d,
                      input int hold, input string rtag);
    int n;
    @(negedge clk);
    addr = a; rd_wr = !wr; wdata = d;
    @(negedge clk);
    sel_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (done_n && n < 100);
    chk("R3", n, DLY + 3);
    if (wr && in_win(a)) model[a[3:0]] = d;
    if (!wr) chk(rtag, rdata, exp_read(a));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R9", done_n, 1'b0);
    end
    sel_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!done_n && n < 100);
    chk("R8", n, 3);
    @(negedge clk);
    chk("R2", done_n, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", done_n, 1'b1);
    chk("R1", rdata, 8'h00);
    repeat (5) begin @(negedge clk); chk("R2", done_n, 1'b1); end

    for (int i = 0; i < 16; i++) xfer(1, BASE + 16'(i), 8'(i * 37 + 5), 0, "R5");
    for (int i = 0; i < 16; i++) xfer(0, BASE + 16'(i), 8'h00, i % 3, "R5");

    xfer(0, 16'h1234, 8'h00, 1, "R6");
    xfer(0, 16'hFFFF, 8'h00, 0, "R6");
    xfer(0, BASE - 16'd1, 8'h00, 0, "R6");

    xfer(1, BASE + 16'h0010 + 16'd7, 8'hA5, 0, "R7");
    xfer(0, BASE + 16'd7, 8'h00, 0, "R7");
    xfer(1, 16'h0007, 8'h5A, 2, "R7");
    xfer(0, BASE + 16'd7, 8'h00, 0, "R7");

    xfer(1, BASE + 16'd9, 8'h3C, 6, "R9");
    xfer(0, BASE + 16'd9, 8'h00, 0, "R4");

    for (int i = 0; i < 80; i++) begin
      a = ($urandom_range(3, 0) != 0) ? (BASE | 16'($urandom_range(15, 0)))
                                      : 16'($urandom);
      xfer($urandom_range(1, 0) == 1, a, 8'($urandom), $urandom_range(3, 0),
           in_win(a) ? "R4" : "R6");
    end

    // bus reset inside the response delay: write must not land
    @(negedge clk);
    addr = BASE + 16'd3; rd_wr = 1'b0; wdata = ~model[3];
    @(negedge clk);
    sel_n = 1'b0;
    @(negedge clk);
    bus_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin @(negedge clk); chk("R10", done_n, 1'b1); end
    bus_rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); chk("R11", done_n, 1'b1); end
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(0, BASE + 16'd3, 8'h00, 0, "R11");

    // bus reset while completion is low
    @(negedge clk);
    addr = BASE + 16'd4; rd_wr = 1'b1;
    @(negedge clk);
    sel_n = 1'b0;
    repeat (DLY + 3) @(negedge clk);
    chk("R3", done_n, 1'b0);
    bus_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", done_n, 1'b1);
    @(negedge clk);
    bus_rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); chk("R11", done_n, 1'b1); end
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(0, BASE + 16'd4, 8'h00, 0, "R4");

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule